// File: doc/BRIEF.md
# PCIe Configuration Access Filter

This block sits between a memory-mapped configuration window and the PCIe link. Each request carries an address whose upper fields name a bus and a device/function, and whose low bits name a register inside that function. The block splits the address into those fields and decides whether the access may go out on the link. Accepted accesses leave on a valid/ready request port as a decoded configuration request. Refused reads are answered locally with all-ones data, and refused writes are discarded without any response.

Two gates apply. The bus directly below the root port (the root bus, whose number is programmable) holds a single device, so only device/function 0 there is reachable; it is reachable whatever the link state. Any other bus number is reachable only while the link training state machine reports the L0 state. The block takes one request at a time: while a forwarded request waits for the downstream side, the request input is not ready.

Top module: `ecam_cfg_filter`

## Requirements
- R1: An accepted request appears on the forward port with bus = cfgAddr[27:20], devfn = cfgAddr[19:12] (device in bits 19:15, function in bits 14:12), register offset = cfgAddr[11:0], and the request's write flag and write data.
- R2: A request to the root bus with a nonzero devfn is refused, whether or not the link is up.
- R3: A request to the root bus with devfn 0 is forwarded, whether or not the link is up.
- R4: A request to any bus other than the root bus is forwarded only if bit 4 (mask 0x10) of ltssmState is set in the cycle it is taken; otherwise it is refused.
- R5: A refused read raises rspValid for exactly the one cycle after it is taken, with rspData all ones; rspValid is never high for any other reason.
- R6: A refused write produces neither a forwarded request nor a response.
- R7: A forwarded request keeps fwdValid high and every forward field unchanged until the cycle fwdReady is high; in the cycle after that handshake fwdValid is low.
- R8: cfgReady is low whenever fwdValid is high, and a request offered while cfgReady is low is not taken and changes nothing.
- R9: The root bus number is 0 after reset and takes rootValue on a clock edge where rootLoad is high; the new value governs requests taken from the next cycle on.
- R10: After reset fwdValid and rspValid are low and cfgReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | A configuration request is offered |
| cfgWrite | input | 1 | 1 = write, 0 = read |
| cfgAddr | input | 28 | Window address: bus, devfn, register offset |
| cfgWdata | input | 32 | Write data |
| cfgReady | output | 1 | A request offered now will be taken |
| rootLoad | input | 1 | Load rootValue as the root bus number |
| rootValue | input | 8 | New root bus number |
| ltssmState | input | 6 | Link training state value; bit 4 means L0 |
| fwdValid | output | 1 | Forwarded request pending |
| fwdReady | input | 1 | Downstream takes the forwarded request |
| fwdWrite | output | 1 | Forwarded request is a write |
| fwdBus | output | 8 | Forwarded bus number |
| fwdDevFn | output | 8 | Forwarded device/function |
| fwdReg | output | 12 | Forwarded register offset |
| fwdWdata | output | 32 | Forwarded write data |
| rspValid | output | 1 | Local completion of a refused read |
| rspData | output | 32 | Local completion data |

## Verification
The bench aims at the link-state bit boundary (state 0x0F versus 0x10), at devfn values that differ from zero only in the function bits, and at a root bus moved away from zero so that bus 0 becomes a gated downstream bus; a design that tested the wrong bit, compared only the device bits or kept a hard-wired root would forward or refuse the wrong request there. It stalls the forward port and offers a second request meanwhile, which catches a design that overwrites the pending fields or lets cfgReady rise early. Back-to-back refused reads check that each gets its own completion cycle, and refused writes check that no stray completion is raised.

// File: rtl/ecam_filter_pkg.sv
package ecam_filter_pkg;

  // Strobes the control sends to the datapath.
  typedef struct packed {
    logic takeFwd;     // capture a forwarded request
    logic takeRsp;     // produce a local all-ones completion
    logic loadRoot;    // update the root bus number
  } ctrlStrobe_t;

  // Decoded facts the datapath hands to the control.
  typedef struct packed {
    logic onRootBus;
    logic devFnZero;
    logic linkUp;
  } decodeFlags_t;

  typedef enum logic [1:0] {
    DEC_FORWARD = 2'd0,
    DEC_REPLY   = 2'd1,
    DEC_DROP    = 2'd2
  } decision_t;

endpackage

// File: rtl/ecam_filter_ctrl.sv
module ecam_filter_ctrl
  import ecam_filter_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgValid,
  input  logic         cfgWrite,
  input  logic         rootLoad,
  input  logic         fwdReady,
  input  decodeFlags_t flags,
  output ctrlStrobe_t  strobe,
  output logic         cfgReady,
  output logic         fwdValid,
  output logic         rspValid
);

  logic      take;
  decision_t decision;
  logic      allowed;

  assign cfgReady = !fwdValid;
  assign take     = cfgValid && cfgReady;

  // Root bus: only devfn 0; other buses: only with link in L0.
  always_comb begin
    if (flags.onRootBus) allowed = flags.devFnZero;
    else                 allowed = flags.linkUp;
    if (allowed)       decision = DEC_FORWARD;
    else if (cfgWrite) decision = DEC_DROP;
    else               decision = DEC_REPLY;
  end

  always_comb begin
    strobe.takeFwd  = take && (decision == DEC_FORWARD);
    strobe.takeRsp  = take && (decision == DEC_REPLY);
    strobe.loadRoot = rootLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      rspValid <= strobe.takeRsp;
      if (strobe.takeFwd)           fwdValid <= 1'b1;
      else if (fwdValid && fwdReady) fwdValid <= 1'b0;
    end
  end

endmodule

// File: rtl/ecam_filter_dp.sv
module ecam_filter_dp
  import ecam_filter_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int DEVFN_W  = 8,
  parameter int REG_W    = 12,
  parameter int DATA_W   = 32,
  parameter int LTSSM_W  = 6,
  parameter int L0_BIT   = 4,
  parameter int ROOT_RST = 0,
  localparam int ADDR_W  = BUS_W + DEVFN_W + REG_W
)(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic                cfgWrite,
  input  logic [DATA_W-1:0]   cfgWdata,
  input  logic [BUS_W-1:0]    rootValue,
  input  logic [LTSSM_W-1:0]  ltssmState,
  output decodeFlags_t        flags,
  output logic [BUS_W-1:0]    rootBusQ,
  output logic                fwdWrite,
  output logic [BUS_W-1:0]    fwdBus,
  output logic [DEVFN_W-1:0]  fwdDevFn,
  output logic [REG_W-1:0]    fwdReg,
  output logic [DATA_W-1:0]   fwdWdata,
  output logic [DATA_W-1:0]   rspData
);

  localparam int DEVFN_LSB = REG_W;
  localparam int BUS_LSB   = REG_W + DEVFN_W;
  localparam logic [LTSSM_W-1:0] L0_MASK = LTSSM_W'(1) << L0_BIT;

  logic [BUS_W-1:0]   reqBus;
  logic [DEVFN_W-1:0] reqDevFn;
  logic [REG_W-1:0]   reqReg;

  assign reqBus   = cfgAddr[BUS_LSB +: BUS_W];
  assign reqDevFn = cfgAddr[DEVFN_LSB +: DEVFN_W];
  assign reqReg   = cfgAddr[0 +: REG_W];

  always_comb begin
    flags.onRootBus = (reqBus == rootBusQ);
    flags.devFnZero = (reqDevFn == '0);
    flags.linkUp    = |(ltssmState & L0_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) rootBusQ <= BUS_W'(ROOT_RST);
    else if (strobe.loadRoot) rootBusQ <= rootValue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdWrite <= 1'b0;
      fwdBus   <= '0;
      fwdDevFn <= '0;
      fwdReg   <= '0;
      fwdWdata <= '0;
    end else if (strobe.takeFwd) begin
      fwdWrite <= cfgWrite;
      fwdBus   <= reqBus;
      fwdDevFn <= reqDevFn;
      fwdReg   <= reqReg;
      fwdWdata <= cfgWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspData <= '0;
    else       rspData <= strobe.takeRsp ? '1 : '0;
  end

endmodule

// File: rtl/ecam_cfg_filter.sv
module ecam_cfg_filter
  import ecam_filter_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int DEVFN_W  = 8,
  parameter int REG_W    = 12,
  parameter int DATA_W   = 32,
  parameter int LTSSM_W  = 6,
  parameter int L0_BIT   = 4,
  parameter int ROOT_RST = 0,
  localparam int ADDR_W  = BUS_W + DEVFN_W + REG_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgValid,
  input  logic               cfgWrite,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgWdata,
  output logic               cfgReady,
  input  logic               rootLoad,
  input  logic [BUS_W-1:0]   rootValue,
  input  logic [LTSSM_W-1:0] ltssmState,
  output logic               fwdValid,
  input  logic               fwdReady,
  output logic               fwdWrite,
  output logic [BUS_W-1:0]   fwdBus,
  output logic [DEVFN_W-1:0] fwdDevFn,
  output logic [REG_W-1:0]   fwdReg,
  output logic [DATA_W-1:0]  fwdWdata,
  output logic               rspValid,
  output logic [DATA_W-1:0]  rspData
);

  ctrlStrobe_t  strobe;
  decodeFlags_t flags;
  logic [BUS_W-1:0] rootBusQ;

  ecam_filter_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgValid (cfgValid),
    .cfgWrite (cfgWrite),
    .rootLoad (rootLoad),
    .fwdReady (fwdReady),
    .flags    (flags),
    .strobe   (strobe),
    .cfgReady (cfgReady),
    .fwdValid (fwdValid),
    .rspValid (rspValid)
  );

  ecam_filter_dp #(
    .BUS_W    (BUS_W),
    .DEVFN_W  (DEVFN_W),
    .REG_W    (REG_W),
    .DATA_W   (DATA_W),
    .LTSSM_W  (LTSSM_W),
    .L0_BIT   (L0_BIT),
    .ROOT_RST (ROOT_RST)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgAddr    (cfgAddr),
    .cfgWrite   (cfgWrite),
    .cfgWdata   (cfgWdata),
    .rootValue  (rootValue),
    .ltssmState (ltssmState),
    .flags      (flags),
    .rootBusQ   (rootBusQ),
    .fwdWrite   (fwdWrite),
    .fwdBus     (fwdBus),
    .fwdDevFn   (fwdDevFn),
    .fwdReg     (fwdReg),
    .fwdWdata   (fwdWdata),
    .rspData    (rspData)
  );

endmodule

// File: rtl/ecam_cfg_filter_chk.sv
module ecam_cfg_filter_chk #(
  parameter int BUS_W   = 8,
  parameter int DEVFN_W = 8,
  parameter int REG_W   = 12,
  parameter int DATA_W  = 32,
  parameter int LTSSM_W = 6,
  parameter int L0_BIT  = 4,
  localparam int ADDR_W = BUS_W + DEVFN_W + REG_W
)(
  input logic               clk,
  input logic               rstN,
  input logic               cfgValid,
  input logic               cfgWrite,
  input logic [ADDR_W-1:0]  cfgAddr,
  input logic               cfgReady,
  input logic [LTSSM_W-1:0] ltssmState,
  input logic [BUS_W-1:0]   rootBusQ,
  input logic               fwdValid,
  input logic               fwdReady,
  input logic               fwdWrite,
  input logic [BUS_W-1:0]   fwdBus,
  input logic [DEVFN_W-1:0] fwdDevFn,
  input logic [REG_W-1:0]   fwdReg,
  input logic [DATA_W-1:0]  fwdWdata,
  input logic               rspValid,
  input logic [DATA_W-1:0]  rspData
);

  logic taken;
  assign taken = cfgValid && cfgReady;

  p_fields_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fwdValid) |-> (fwdBus == $past(cfgAddr[ADDR_W-1 -: BUS_W]))
                     && (fwdDevFn == $past(cfgAddr[REG_W +: DEVFN_W]))
                     && (fwdReg == $past(cfgAddr[REG_W-1:0])));

  p_root_fn0_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fwdValid) && (fwdBus == $past(rootBusQ)) |-> (fwdDevFn == '0));

  p_link_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fwdValid) && (fwdBus != $past(rootBusQ)) |-> $past(ltssmState[L0_BIT]));

  p_rsp_ones_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (&rspData));

  p_rsp_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(taken && !cfgWrite));

  p_wr_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(taken && cfgWrite) && !$rose(fwdValid) |-> !rspValid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid && !fwdReady |=> fwdValid && $stable(fwdBus) && $stable(fwdDevFn)
                           && $stable(fwdReg) && $stable(fwdWrite) && $stable(fwdWdata));

  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid && fwdReady |=> !fwdValid);

  p_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> !cfgReady);

endmodule

bind ecam_cfg_filter ecam_cfg_filter_chk #(
  .BUS_W   (BUS_W),
  .DEVFN_W (DEVFN_W),
  .REG_W   (REG_W),
  .DATA_W  (DATA_W),
  .LTSSM_W (LTSSM_W),
  .L0_BIT  (L0_BIT)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgValid   (cfgValid),
  .cfgWrite   (cfgWrite),
  .cfgAddr    (cfgAddr),
  .cfgReady   (cfgReady),
  .ltssmState (ltssmState),
  .rootBusQ   (rootBusQ),
  .fwdValid   (fwdValid),
  .fwdReady   (fwdReady),
  .fwdWrite   (fwdWrite),
  .fwdBus     (fwdBus),
  .fwdDevFn   (fwdDevFn),
  .fwdReg     (fwdReg),
  .fwdWdata   (fwdWdata),
  .rspValid   (rspValid),
  .rspData    (rspData)
);

// File: tb/tb_ecam_cfg_filter.sv
module tb_ecam_cfg_filter;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgValid = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [27:0] cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic        cfgReady;
  logic        rootLoad = 1'b0;
  logic [7:0]  rootValue = '0;
  logic [5:0]  ltssmState = '0;
  logic        fwdValid;
  logic        fwdReady = 1'b1;
  logic        fwdWrite;
  logic [7:0]  fwdBus;
  logic [7:0]  fwdDevFn;
  logic [11:0] fwdReg;
  logic [31:0] fwdWdata;
  logic        rspValid;
  logic [31:0] rspData;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecam_cfg_filter dut (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgReady(cfgReady),
    .rootLoad(rootLoad), .rootValue(rootValue), .ltssmState(ltssmState),
    .fwdValid(fwdValid), .fwdReady(fwdReady), .fwdWrite(fwdWrite),
    .fwdBus(fwdBus), .fwdDevFn(fwdDevFn), .fwdReg(fwdReg),
    .fwdWdata(fwdWdata), .rspValid(rspValid), .rspData(rspData)
  );

  // Behavioural reference state.
  logic        mFwd = 0, mWr = 0, mRsp = 0;
  logic [7:0]  mBus = 0, mDevFn = 0, mRoot = 0;
  logic [11:0] mReg = 0;
  logic [31:0] mData = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mFwd = 0; mRsp = 0; mRoot = 0;
    end else begin
      logic busyOld;
      logic ok;
      logic [7:0] b;
      logic [7:0] df;
      busyOld = mFwd;
      b  = cfgAddr[27:20];
      df = cfgAddr[19:12];
      if (b == mRoot) ok = (df == 0);
      else            ok = (ltssmState & 6'h10) != 0;
      if (mFwd && fwdReady) mFwd = 0;
      mRsp = 0;
      if (cfgValid && !busyOld) begin
        if (ok) begin
          mFwd = 1; mBus = b; mDevFn = df; mReg = cfgAddr[11:0];
          mWr = cfgWrite; mData = cfgWdata;
        end else if (!cfgWrite) mRsp = 1;
      end
      if (rootLoad) mRoot = rootValue;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle compare against the reference.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(fwdValid == mFwd, "R4 fwdValid", fwdValid, mFwd);
      chk(cfgReady == !mFwd, "R8 cfgReady", cfgReady, !mFwd);
      chk(rspValid == mRsp, "R5 rspValid", rspValid, mRsp);
      if (mRsp) chk(rspData == 32'hFFFF_FFFF, "R5 rspData", rspData, 32'hFFFF_FFFF);
      if (mFwd) begin
        chk({fwdBus, fwdDevFn, fwdReg} == {mBus, mDevFn, mReg}, "R1 fields",
            {fwdBus, fwdDevFn, fwdReg}, {mBus, mDevFn, mReg});
        chk({fwdWrite, fwdWdata} == {mWr, mData}, "R1 wdata",
            {fwdWrite, fwdWdata}, {mWr, mData});
      end
    end
  end

  function automatic logic [27:0] mkAddr(input logic [7:0] bus, input logic [4:0] dev,
                                         input logic [2:0] fn, input logic [11:0] rg);
    return {bus, dev, fn, rg};
  endfunction

  task automatic issue(input logic [27:0] a, input logic w, input logic [31:0] d);
    cfgAddr = a; cfgWrite = w; cfgWdata = d; cfgValid = 1;
    @(negedge clk);
    cfgValid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10: reset state
    chk(cfgReady == 1 && fwdValid == 0 && rspValid == 0, "R10 idle",
        {cfgReady, fwdValid, rspValid}, 3'b100);

    // R3 / R9: root bus 0 by default, devfn 0 forwarded with link down
    ltssmState = 6'h00;
    issue(mkAddr(8'd0, 5'd0, 3'd0, 12'h010), 0, 0);
    chk(fwdValid && fwdBus == 0 && fwdReg == 12'h010, "R3 root fn0 forwarded",
        {fwdValid, fwdBus}, 9'h100);
    @(negedge clk);

    // R2: root bus, only function bits nonzero
    issue(mkAddr(8'd0, 5'd0, 3'd1, 12'h000), 0, 0);
    chk(rspValid && !fwdValid, "R2 root fn1 refused", {rspValid, fwdValid}, 2'b10);
    @(negedge clk);
    chk(!rspValid, "R5 single cycle", rspValid, 0);
    ltssmState = 6'h10;
    issue(mkAddr(8'd0, 5'd3, 3'd0, 12'h004), 0, 0);
    chk(rspValid && !fwdValid, "R2 refused with link up", {rspValid, fwdValid}, 2'b10);

    // R6: refused write silent
    ltssmState = 6'h00;
    issue(mkAddr(8'd0, 5'd1, 3'd0, 12'h008), 1, 32'h1234);
    chk(!rspValid && !fwdValid, "R6 write dropped", {rspValid, fwdValid}, 0);
    issue(mkAddr(8'd7, 5'd0, 3'd0, 12'h008), 1, 32'h55);
    chk(!rspValid && !fwdValid, "R6 downstream write dropped", {rspValid, fwdValid}, 0);

    // R4: link bit boundary
    ltssmState = 6'h0F;
    issue(mkAddr(8'd2, 5'd0, 3'd0, 12'h100), 0, 0);
    chk(rspValid && !fwdValid, "R4 state 0x0F refused", {rspValid, fwdValid}, 2'b10);
    ltssmState = 6'h10;
    issue(mkAddr(8'd2, 5'd4, 3'd2, 12'h100), 0, 0);
    chk(fwdValid && fwdBus == 8'd2 && fwdDevFn == 8'h22, "R4 state 0x10 forwarded",
        {fwdValid, fwdBus, fwdDevFn}, {1'b1, 8'd2, 8'h22});
    @(negedge clk);
    ltssmState = 6'h11;
    issue(mkAddr(8'd7, 5'd31, 3'd7, 12'hFFC), 1, 32'hCAFE_F00D);
    chk(fwdValid && fwdWrite && fwdWdata == 32'hCAFE_F00D && fwdReg == 12'hFFC,
        "R1 write forwarded", fwdWdata, 32'hCAFE_F00D);
    @(negedge clk);

    // R7 / R8: stall
    fwdReady = 0;
    issue(mkAddr(8'd3, 5'd1, 3'd1, 12'h020), 1, 32'hA5A5_0001);
    repeat (2) @(negedge clk);
    chk(fwdValid && !cfgReady, "R7 held while not ready", {fwdValid, cfgReady}, 2'b10);
    issue(mkAddr(8'd9, 5'd2, 3'd0, 12'h030), 0, 0);
    chk(fwdBus == 8'd3 && fwdReg == 12'h020 && !rspValid, "R8 offer ignored",
        {fwdBus, fwdReg}, {8'd3, 12'h020});
    fwdReady = 1;
    @(negedge clk);
    chk(!fwdValid && cfgReady, "R7 released", fwdValid, 0);

    // R9: move the root bus
    rootLoad = 1; rootValue = 8'd5;
    @(negedge clk);
    rootLoad = 0;
    ltssmState = 6'h00;
    issue(mkAddr(8'd5, 5'd0, 3'd0, 12'h000), 0, 0);
    chk(fwdValid && fwdBus == 8'd5, "R9 new root forwarded", fwdValid, 1);
    @(negedge clk);
    issue(mkAddr(8'd0, 5'd0, 3'd0, 12'h000), 0, 0);
    chk(rspValid && !fwdValid, "R9 old root now gated", {rspValid, fwdValid}, 2'b10);

    // R5: back-to-back refused reads
    cfgAddr = mkAddr(8'd5, 5'd0, 3'd4, 12'h0); cfgWrite = 0; cfgValid = 1;
    @(negedge clk);
    chk(rspValid, "R5 first", rspValid, 1);
    @(negedge clk);
    cfgValid = 0;
    chk(rspValid, "R5 second", rspValid, 1);

    // Mixed traffic, compared cycle by cycle.
    for (int i = 0; i < 400; i++) begin
      logic [7:0] b;
      int sel;
      sel = $urandom_range(0, 3);
      b = (sel == 0) ? 8'd5 : (sel == 1) ? 8'd0 : 8'($urandom_range(0, 255));
      cfgAddr  = {b, (($urandom_range(0, 1) == 0) ? 8'h00 : 8'($urandom)), 12'($urandom)};
      cfgWrite = 1'($urandom);
      cfgWdata = $urandom;
      cfgValid = ($urandom_range(0, 3) != 0);
      ltssmState = 6'($urandom);
      fwdReady = ($urandom_range(0, 2) != 0);
      rootLoad = ($urandom_range(0, 40) == 0);
      rootValue = 8'($urandom_range(0, 6));
      @(negedge clk);
    end
    cfgValid = 0; rootLoad = 0; fwdReady = 1;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule